// File: doc/BRIEF.md
# Write Response Timing Monitor

A passive observer for the write-data and write-response channels of an AXI-style subordinate port. It never drives the bus. On every rising clock edge it samples the write-beat handshake and the response handshake. It reports a one-cycle pulse for each rule broken at that edge, and a sticky flag that records whether any rule has been broken since reset.

A burst closes only on an edge where the last-beat marker, the data-valid and the data-ready inputs are all high. The monitor keeps a count of closed bursts that have not yet been answered, so several bursts may be outstanding at once. A response is legal only when that count, as it stood before the current edge, is non-zero. A burst that closes on the same edge therefore cannot cover a response raised in that cycle. A response that is waiting for acceptance must keep its valid high and its status code unchanged until the handshake. The count is bounded by a parameter, and going past that bound is reported as an error.

The monitor is meant to sit beside a subordinate in simulation or in silicon as a protocol watchdog. Address ordering, transaction IDs, data content and interleaving are not checked.

Top module: `wr_resp_monitor`

## Requirements
- R1: A burst is counted as closed only on a clock edge where `wr_last`, `wr_valid` and `wr_ready` are all 1. If `wr_last` is high while either of the other two is low, nothing is counted, and a later response with no other burst outstanding raises `err_early`.
- R2: If `rsp_valid` is 1 on an edge where the outstanding count, as held before that edge, is zero, `err_early` is 1 in the following cycle. This includes the case where the final beat is accepted on that same edge.
- R3: `rsp_valid` on an edge with a non-zero outstanding count raises no error. A response handshake (`rsp_valid` and `rsp_ready` both 1) on such an edge reduces the count by one. The sequence "non-last beat accepted, last beat accepted, response with handshake on the next cycle" raises no error.
- R4: If an edge sees `rsp_valid`=1 and `rsp_ready`=0, and `rsp_valid` is 0 on the next edge, `err_hold` is 1 in the cycle after that next edge.
- R5: If an edge sees `rsp_valid`=1 and `rsp_ready`=0, and `rsp_code` differs on the next edge, `err_hold` is 1 in the cycle after that next edge. The status codes are 2'b00 OKAY, 2'b01 EXOKAY, 2'b10 SLVERR and 2'b11 DECERR.
- R6: If a burst closes on an edge where the count is already `MAX_OUT` and no response handshake takes place on that edge, `err_ovf` is 1 in the following cycle, and the count stays at `MAX_OUT`.
- R7: `err_sticky` is 1 from the first cycle in which any violation output is 1, and it stays 1 until reset.
- R8: A synchronous active-high `rst` clears the count, the pending-response state, all three violation outputs and `err_sticky`.
- R9: Each violation output is high for exactly the one cycle after each edge that breaks its rule, and it returns to 0 after an edge that breaks nothing.
- R10: Up to `MAX_OUT` bursts may be outstanding. With N bursts closed and no response yet, N responses are legal in turn, and response N+1 raises `err_early`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write-data valid, from the manager |
| wr_ready | input | 1 | Write-data ready, from the subordinate |
| wr_last | input | 1 | Last-beat marker of the write burst |
| rsp_valid | input | 1 | Write-response valid, from the subordinate |
| rsp_ready | input | 1 | Write-response ready, from the manager |
| rsp_code | input | 2 | Write-response status code |
| err_early | output | 1 | Pulse: response with no closed burst outstanding |
| err_hold | output | 1 | Pulse: a waiting response dropped valid or changed its code |
| err_ovf | output | 1 | Pulse: outstanding-burst count would exceed `MAX_OUT` |
| err_sticky | output | 1 | Any violation since reset |

## Verification
A wrong outstanding count stays hidden until the next response. One count too few shows as a spurious `err_early` one cycle after a legal response. One too many suppresses the pulse for an unmatched response, or fires `err_ovf` one burst early. For this reason the stimulus pairs each burst pattern with a response that probes the count straight away. A stale pending flag or saved code in the stall checker shows as an `err_hold` pulse on the first edge after an accepted or abandoned response. A reference model compares all four outputs every cycle, so such a fault is reported within one clock.

// File: rtl/wr_resp_monitor_pkg.sv
package wr_resp_monitor_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_code_e;

    typedef struct packed {
        logic early;
        logic hold;
        logic ovf;
    } viol_t;

    localparam viol_t VIOL_NONE = '{early: 1'b0, hold: 1'b0, ovf: 1'b0};

    function automatic logic burst_closes(input logic v, input logic r, input logic l);
        return v & r & l;
    endfunction

    function automatic logic any_viol(input viol_t v);
        return v.early | v.hold | v.ovf;
    endfunction

endpackage

// File: rtl/bmon_outstanding.sv
module bmon_outstanding
    import wr_resp_monitor_pkg::*;
#(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic beat_fin,
    input  logic rsp_valid,
    input  logic rsp_ready,
    output logic early_evt,
    output logic ovf_evt
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;
    logic             has_open;
    logic             retire;
    logic             admit;

    always_comb begin
        has_open  = (cnt_q != '0);
        retire    = rsp_valid & rsp_ready & has_open;
        ovf_evt   = beat_fin & (cnt_q == CNT_MAX) & ~retire;
        admit     = beat_fin & ~ovf_evt;
        early_evt = rsp_valid & ~has_open;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({admit, retire})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R6 / R10: the count never leaves its legal range
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX)
        else $error("outstanding count above limit");

    // R3: a response handshake with work open lowers the count unless a burst also closes
    a_r3_handshake_retires: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && cnt_q != '0 && !beat_fin) |=> cnt_q == $past(cnt_q) - 1'b1)
        else $error("handshake did not retire a burst");

    // R1: without a closing beat the count cannot grow
    a_r1_no_growth_without_close: assert property (@(posedge clk) disable iff (rst)
        !beat_fin |=> cnt_q <= $past(cnt_q))
        else $error("count grew without a closing beat");
endmodule

// File: rtl/bmon_stall_check.sv
module bmon_stall_check
    import wr_resp_monitor_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rsp_valid,
    input  logic       rsp_ready,
    input  rsp_code_e  rsp_code,
    output logic       hold_evt
);
    logic      pend_q;
    rsp_code_e code_q;

    always_comb begin
        hold_evt = pend_q & (~rsp_valid | (rsp_code != code_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            code_q <= RSP_OKAY;
        end else begin
            pend_q <= rsp_valid & ~rsp_ready;
            code_q <= rsp_code;
        end
    end

    // R4: a stall is pending only after an edge that saw valid without ready
    a_r4_pend_origin: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $past(rsp_valid && !rsp_ready))
        else $error("pending without stalled response");

    // R5: a stall that keeps valid and code raises nothing
    a_r5_quiet_when_stable: assert property (@(posedge clk) disable iff (rst)
        (pend_q && rsp_valid && rsp_code == code_q) |-> !hold_evt)
        else $error("hold violation on stable response");
endmodule

// File: rtl/bmon_viol_reg.sv
module bmon_viol_reg
    import wr_resp_monitor_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  viol_t evt,
    output viol_t pulse_q,
    output logic  sticky_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q  <= VIOL_NONE;
            sticky_q <= 1'b0;
        end else begin
            pulse_q  <= evt;
            sticky_q <= sticky_q | any_viol(evt);
        end
    end

    // R7: sticky never falls while out of reset
    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        sticky_q |=> sticky_q)
        else $error("sticky flag dropped");

    // R7: any pulse is accompanied by the sticky flag
    a_r7_pulse_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        any_viol(pulse_q) |-> sticky_q)
        else $error("pulse without sticky");

    // R9: a pulse reflects only the previous edge's event
    a_r9_pulse_one_edge: assert property (@(posedge clk) disable iff (rst)
        pulse_q.early |-> $past(evt.early))
        else $error("early pulse without event");
endmodule

// File: rtl/wr_resp_monitor.sv
module wr_resp_monitor
    import wr_resp_monitor_pkg::*;
#(
    parameter int MAX_OUT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic       wr_ready,
    input  logic       wr_last,
    input  logic       rsp_valid,
    input  logic       rsp_ready,
    input  logic [1:0] rsp_code,
    output logic       err_early,
    output logic       err_hold,
    output logic       err_ovf,
    output logic       err_sticky
);
    logic  beat_fin;
    viol_t evt;
    viol_t pulse;

    assign beat_fin = burst_closes(wr_valid, wr_ready, wr_last);

    bmon_outstanding #(.MAX_OUT(MAX_OUT)) u_count (
        .clk       (clk),
        .rst       (rst),
        .beat_fin  (beat_fin),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .early_evt (evt.early),
        .ovf_evt   (evt.ovf)
    );

    bmon_stall_check u_stall (
        .clk       (clk),
        .rst       (rst),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_code  (rsp_code_e'(rsp_code)),
        .hold_evt  (evt.hold)
    );

    bmon_viol_reg u_viol (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pulse_q  (pulse),
        .sticky_q (err_sticky)
    );

    assign err_early = pulse.early;
    assign err_hold  = pulse.hold;
    assign err_ovf   = pulse.ovf;

    // R2: an early pulse follows an edge that carried a response
    a_r2_early_needs_rsp: assert property (@(posedge clk) disable iff (rst)
        err_early |-> $past(rsp_valid))
        else $error("early pulse without response");

    // R6: overflow only after a closing beat
    a_r6_ovf_needs_close: assert property (@(posedge clk) disable iff (rst)
        err_ovf |-> $past(wr_valid && wr_ready && wr_last))
        else $error("overflow without closing beat");
endmodule

// File: tb/wr_resp_monitor_bench.sv
module wr_resp_monitor_bench;
    localparam int MAX_OUT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wv = 1'b0, wr = 1'b0, wl = 1'b0, bv = 1'b0, br = 1'b0;
    logic [1:0] code = 2'b00;
    logic err_early, err_hold, err_ovf, err_sticky;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wr_resp_monitor #(.MAX_OUT(MAX_OUT)) u_wr_resp_monitor (
        .clk(clk), .rst(rst), .wr_valid(wv), .wr_ready(wr), .wr_last(wl),
        .rsp_valid(bv), .rsp_ready(br), .rsp_code(code),
        .err_early(err_early), .err_hold(err_hold), .err_ovf(err_ovf),
        .err_sticky(err_sticky)
    );

    // behavioural reference: outstanding responses owed, held in a queue
    int   owed[$];
    bit   m_pend = 0;
    logic [1:0] m_code = 2'b00;
    bit   e_early = 0, e_hold = 0, e_ovf = 0, e_sticky = 0;
    bit   started = 0;

    always @(posedge clk) begin
        if (rst) begin
            owed.delete();
            m_pend = 0; m_code = 2'b00;
            e_early = 0; e_hold = 0; e_ovf = 0; e_sticky = 0;
        end else begin
            bit closes, paid;
            closes  = wv && wr && wl;
            e_early = bv && owed.size() == 0;
            e_hold  = m_pend && (!bv || code != m_code);
            paid    = bv && br && owed.size() > 0;
            e_ovf   = closes && owed.size() == MAX_OUT && !paid;
            if (paid) void'(owed.pop_front());
            if (closes && !e_ovf) owed.push_back(1);
            m_pend  = bv && !br;
            m_code  = code;
            if (e_early || e_hold || e_ovf) e_sticky = 1;
        end
        started = 1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R2 model err_early", err_early, e_early);
            chk("R4 model err_hold", err_hold, e_hold);
            chk("R6 model err_ovf", err_ovf, e_ovf);
            chk("R7 model err_sticky", err_sticky, e_sticky);
        end
    end

    task automatic cyc(input logic v, input logic r, input logic l,
                       input logic b, input logic a, input logic [1:0] c);
        @(negedge clk);
        wv = v; wr = r; wl = l; bv = b; br = a; code = c;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wv = 0; wr = 0; wl = 0; bv = 0; br = 0; code = 2'b00;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R8 reset err_early", err_early, 1'b0);
        chk("R8 reset err_sticky", err_sticky, 1'b0);
        do_reset();

        // R3: example sequence
        cyc(1, 1, 0, 0, 0, 2'b00);
        cyc(1, 1, 1, 0, 0, 2'b00);
        cyc(0, 0, 0, 1, 1, 2'b00);
        idle();
        chk("R3 legal response no early", err_early, 1'b0);
        chk("R3 legal response no sticky", err_sticky, 1'b0);

        // R1: last without valid, then response
        cyc(0, 1, 1, 0, 0, 2'b00);
        cyc(0, 0, 0, 1, 1, 2'b01);
        chk("R1 last without valid -> early", err_early, 1'b1);
        chk("R7 sticky set", err_sticky, 1'b1);
        idle();
        chk("R9 pulse returns low", err_early, 1'b0);
        // R1: last with valid but no ready
        cyc(1, 0, 1, 0, 0, 2'b00);
        cyc(0, 0, 0, 1, 1, 2'b00);
        chk("R1 last without ready -> early", err_early, 1'b1);
        idle();

        // R2: response on the same edge as the closing beat
        do_reset();
        chk("R8 reset clears sticky", err_sticky, 1'b0);
        cyc(1, 1, 1, 1, 1, 2'b00);
        chk("R2 same-cycle response early", err_early, 1'b1);
        cyc(0, 0, 0, 1, 1, 2'b10);
        chk("R3 burst still owed after early", err_early, 1'b0);
        idle();

        // R10: three outstanding bursts
        do_reset();
        cyc(1, 1, 1, 0, 0, 2'b00);
        cyc(1, 1, 1, 0, 0, 2'b00);
        cyc(1, 1, 1, 0, 0, 2'b00);
        cyc(0, 0, 0, 1, 1, 2'b00);
        cyc(0, 0, 0, 1, 1, 2'b01);
        cyc(0, 0, 0, 1, 1, 2'b00);
        chk("R10 third response legal", err_early, 1'b0);
        cyc(0, 0, 0, 1, 1, 2'b00);
        chk("R10 fourth response early", err_early, 1'b1);
        idle();

        // R4 / R5: stall stability
        do_reset();
        cyc(1, 1, 1, 0, 0, 2'b00);
        cyc(0, 0, 0, 1, 0, 2'b10);
        chk("R4 stall start no hold", err_hold, 1'b0);
        cyc(0, 0, 0, 0, 0, 2'b10);
        chk("R4 valid dropped -> hold", err_hold, 1'b1);
        cyc(0, 0, 0, 1, 0, 2'b10);
        chk("R4 restart no hold", err_hold, 1'b0);
        cyc(0, 0, 0, 1, 0, 2'b11);
        chk("R5 code changed -> hold", err_hold, 1'b1);
        cyc(0, 0, 0, 1, 1, 2'b11);
        chk("R5 stable handshake no hold", err_hold, 1'b0);
        chk("R3 stalled response legal", err_early, 1'b0);
        idle();
        chk("R9 hold returns low", err_hold, 1'b0);

        // R6: overflow
        do_reset();
        for (int i = 0; i < MAX_OUT; i++) cyc(1, 1, 1, 0, 0, 2'b00);
        chk("R6 at limit no ovf", err_ovf, 1'b0);
        cyc(1, 1, 1, 0, 0, 2'b00);
        chk("R6 past limit ovf", err_ovf, 1'b1);
        cyc(1, 1, 1, 1, 1, 2'b00);
        chk("R6 close with retire no ovf", err_ovf, 1'b0);
        for (int i = 0; i < MAX_OUT; i++) cyc(0, 0, 0, 1, 1, 2'b00);
        chk("R6 saturated count drains", err_early, 1'b0);
        cyc(0, 0, 0, 1, 1, 2'b00);
        chk("R6 drained then early", err_early, 1'b1);
        idle();
        chk("R7 sticky held", err_sticky, 1'b1);

        do_reset();
        idle();
        chk("R8 reset clears ovf", err_ovf, 1'b0);
        chk("R8 reset clears sticky again", err_sticky, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule